// File: doc/BRIEF.md
# PCM TDM Serial Port

This block is the digital side of a single-channel voice codec that sits on a time-division-multiplexed highway. In every frame it sends one 8-bit companded word out on a serial data line during its transmit timeslot, and it collects one 8-bit word from the serial input line. The companding arithmetic, the filters and the analog conversion are handled elsewhere. Words to send come in on a parallel port with a load strobe. Received words go out on a parallel port with a one-cycle valid strobe.

The bit clock, both frame syncs, the serial input and the power-down pin are external. They are synchronized into a faster system clock, and their edges are found there. The block sorts each frame sync into one of two kinds by the width of the pulse. A short pulse lasts one or two bit periods. A long pulse lasts three or more. The two kinds have different data-launch rules. Only the transmit slot drives the serial output. The same interval pulls the active-low open-drain timeslot pin low. Holding the power-down pin high for long enough silences the whole port.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset, `txSerialOe`, `slotPullLow` and `rxValid` are all 0, and the sync mode is short.
- R2: In short mode, the bit-clock falling edge that finds the frame sync high marks the frame. The 8 transmit bits follow, most significant first, one on each of the next 8 bit-clock rising edges.
- R3: In long mode, the first transmit bit is launched at the later of two events: the frame sync rising edge or a bit-clock rising edge. If the sync rises while the bit clock is high, the bit is launched at once. Each later bit is launched on a bit-clock rising edge.
- R4: At the third bit-clock falling edge after a sync rise, the sync level is sampled. High selects long mode and low selects short mode. The new mode governs from the next frame onward.
- R5: Receive bits are sampled on bit-clock falling edges, most significant first. In short mode they are the 8 falls after the marking fall. In long mode they are the first 8 falls after the sync rise. The completed word appears on `rxWord` with a one-cycle `rxValid`.
- R6: `txSerialOe` and `slotPullLow` are 1 from the launch of the first bit until the bit-clock falling edge that ends the eighth bit. They stay 0 for the rest of the frame.
- R7: A `txLoad` pulse stages `txWord`. The staged word is taken at the start of the next transmit frame and is sent exactly once. A word staged after a frame has started goes out in the following frame.
- R8: If no word is staged at the start of a frame, the idle code is sent. The idle code is 8'hFF when `lawSelA`=0 and 8'hD5 (11010101) when `lawSelA`=1.
- R9: Holding `pwrDownPin` high for PD_HOLD consecutive system cycles (64 by default) powers the port down. While powered down, `txSerialOe`=0, `slotPullLow`=0, no `rxValid` is produced, and a staged word is kept. A shorter pulse has no effect. Operation resumes with the first frame after the pin returns low.
- R10: While the output is enabled, `txSerial` changes only at a bit launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Active-low reset |
| bitClk | input | 1 | Serial bit clock, shared by both directions |
| txFrameSync | input | 1 | Transmit frame sync |
| rxFrameSync | input | 1 | Receive frame sync |
| rxSerial | input | 1 | Serial receive data |
| pwrDownPin | input | 1 | Power-down request, active high when held |
| lawSelA | input | 1 | Idle code select: 0 gives 8'hFF, 1 gives 8'hD5 |
| txLoad | input | 1 | One-cycle strobe that stages txWord |
| txWord | input | 8 | Parallel transmit word |
| txSerial | output | 1 | Serial transmit data |
| txSerialOe | output | 1 | Output enable for txSerial; 0 means high impedance |
| slotPullLow | output | 1 | 1 pulls the open-drain timeslot pin low |
| rxWord | output | 8 | Last completed receive word |
| rxValid | output | 1 | One-cycle strobe with each new rxWord |

## Verification
The bench sweeps many word pairs through every sync shape: short syncs of one and two bit periods, long syncs rising during a high bit clock, and long syncs rising during a low one. These include the frames where the shape differs from the latched mode. A design that applied its width decision to the current frame would send that frame one bit period early or late. A design that treated a long sync rising in the low phase as an immediate launch would shift every bit. The bench checks the enable and the timeslot pin in the low half of the eighth bit, where a late release would show. It stages a word in the middle of a frame to catch a design that sends it too early. It holds power-down before staging a word and checks that the word survives a silent frame, and it applies a short power-down pulse that must change nothing.

// File: rtl/pcm_tdm_pkg.sv
`timescale 1ns/1ps
package pcm_tdm_pkg;

  localparam int WORD_BITS = 8;

  // silent-line codes for the two companding laws
  localparam logic [WORD_BITS-1:0] IDLE_MU = 8'hFF;
  localparam logic [WORD_BITS-1:0] IDLE_A  = 8'hD5;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_WAIT,
    SLOT_RUN
  } slotState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txFrameStart;
    logic txLaunch;
    logic txDone;
    logic rxFrameStart;
    logic rxSample;
    logic rxDone;
  } strobes_t;

endpackage

// File: rtl/pcm_tdm_sync.sv
`timescale 1ns/1ps
module pcm_tdm_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pcm_tdm_slot_timer.sv
`timescale 1ns/1ps
module pcm_tdm_slot_timer
  import pcm_tdm_pkg::*;
#(
  parameter bit IS_TX     = 1'b1,
  parameter int NBITS     = WORD_BITS,
  parameter int MODE_EDGE = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic halt,
  input  logic syncRise,
  input  logic syncLvl,
  input  logic bcRise,
  input  logic bcFall,
  input  logic bcLvl,
  output logic frameStart,
  output logic bitEdge,
  output logic wordDone
);

  localparam int CNT_W  = $clog2(NBITS + 1);
  localparam int MODE_W = $clog2(MODE_EDGE + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(NBITS);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(NBITS - 1);
  localparam logic [MODE_W-1:0] MODE_AT  = MODE_W'(MODE_EDGE - 1);

  slotState_t       st, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [MODE_W-1:0] fallCnt;
  logic             tracking;
  logic             longMode;

  // width classification: sampled on the MODE_EDGE-th fall after the rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallCnt  <= '0;
      tracking <= 1'b0;
      longMode <= 1'b0;
    end else if (halt) begin
      tracking <= 1'b0;
    end else if (syncRise) begin
      fallCnt  <= '0;
      tracking <= 1'b1;
    end else if (tracking && bcFall) begin
      fallCnt <= fallCnt + 1'b1;
      if (fallCnt == MODE_AT) begin
        longMode <= syncLvl;
        tracking <= 1'b0;
      end
    end
  end

  always_comb begin
    stNext     = st;
    cntNext    = bitCnt;
    bitEdge    = 1'b0;
    wordDone   = 1'b0;
    frameStart = 1'b0;
    if (halt) begin
      stNext  = SLOT_IDLE;
      cntNext = '0;
    end else if (syncRise) begin
      frameStart = 1'b1;
      cntNext    = '0;
      if (longMode) begin
        stNext = SLOT_RUN;
        if (IS_TX && bcLvl) begin
          bitEdge = 1'b1;
          cntNext = CNT_W'(1);
        end
      end else begin
        stNext = SLOT_WAIT;
      end
    end else begin
      case (st)
        SLOT_WAIT: if (bcFall && syncLvl) stNext = SLOT_RUN;
        SLOT_RUN: begin
          if (IS_TX) begin
            if (bcRise && bitCnt != CNT_FULL) begin
              bitEdge = 1'b1;
              cntNext = bitCnt + 1'b1;
            end else if (bcFall && bitCnt == CNT_FULL) begin
              wordDone = 1'b1;
              stNext   = SLOT_IDLE;
            end
          end else if (bcFall) begin
            bitEdge = 1'b1;
            cntNext = bitCnt + 1'b1;
            if (bitCnt == CNT_LAST) begin
              wordDone = 1'b1;
              stNext   = SLOT_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= SLOT_IDLE;
      bitCnt <= '0;
    end else begin
      st     <= stNext;
      bitCnt <= cntNext;
    end
  end

endmodule

// File: rtl/pcm_tdm_ctrl.sv
`timescale 1ns/1ps
module pcm_tdm_ctrl
  import pcm_tdm_pkg::*;
#(
  parameter int PD_HOLD = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bcLvl,
  input  logic     txSyncLvl,
  input  logic     rxSyncLvl,
  input  logic     pdLvl,
  output strobes_t strobes,
  output logic     txInSlot,
  output logic     pdActive
);

  localparam int PD_W = $clog2(PD_HOLD + 1);
  localparam logic [PD_W-1:0] PD_MAX = PD_W'(PD_HOLD);

  logic bcPrev, txsPrev, rxsPrev;
  logic bcRise, bcFall, txsRise, rxsRise;
  logic [PD_W-1:0] pdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcPrev  <= 1'b0;
      txsPrev <= 1'b0;
      rxsPrev <= 1'b0;
    end else begin
      bcPrev  <= bcLvl;
      txsPrev <= txSyncLvl;
      rxsPrev <= rxSyncLvl;
    end
  end

  assign bcRise  = bcLvl & ~bcPrev;
  assign bcFall  = ~bcLvl & bcPrev;
  assign txsRise = txSyncLvl & ~txsPrev;
  assign rxsRise = rxSyncLvl & ~rxsPrev;

  // power-down only after the pin has stayed high for PD_HOLD cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pdCnt <= '0;
    else if (!pdLvl)        pdCnt <= '0;
    else if (pdCnt != PD_MAX) pdCnt <= pdCnt + 1'b1;
  end

  assign pdActive = (pdCnt == PD_MAX);

  pcm_tdm_slot_timer #(.IS_TX(1'b1)) u_txTimer (
    .clk(clk), .rstN(rstN), .halt(pdActive),
    .syncRise(txsRise), .syncLvl(txSyncLvl),
    .bcRise(bcRise), .bcFall(bcFall), .bcLvl(bcLvl),
    .frameStart(strobes.txFrameStart),
    .bitEdge(strobes.txLaunch),
    .wordDone(strobes.txDone)
  );

  pcm_tdm_slot_timer #(.IS_TX(1'b0)) u_rxTimer (
    .clk(clk), .rstN(rstN), .halt(pdActive),
    .syncRise(rxsRise), .syncLvl(rxSyncLvl),
    .bcRise(bcRise), .bcFall(bcFall), .bcLvl(bcLvl),
    .frameStart(strobes.rxFrameStart),
    .bitEdge(strobes.rxSample),
    .wordDone(strobes.rxDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  txInSlot <= 1'b0;
    else if (pdActive)          txInSlot <= 1'b0;
    else if (strobes.txLaunch)  txInSlot <= 1'b1;
    else if (strobes.txDone || strobes.txFrameStart) txInSlot <= 1'b0;
  end

endmodule

// File: rtl/pcm_tdm_dpath.sv
`timescale 1ns/1ps
module pcm_tdm_dpath
  import pcm_tdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic                 lawSelA,
  input  logic                 txLoad,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic                 rxBit,
  output logic                 txSerial,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid
);

  logic [WORD_BITS-1:0] txHold, txShift, freshWord, rxShift;
  logic                 txPend;

  assign freshWord = txPend ? txHold : (lawSelA ? IDLE_A : IDLE_MU);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txPend <= 1'b0;
    end else if (txLoad) begin
      txHold <= txWord;
      txPend <= 1'b1;
    end else if (strobes.txFrameStart) begin
      txPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      txSerial <= 1'b0;
    end else if (strobes.txFrameStart) begin
      if (strobes.txLaunch) begin
        txSerial <= freshWord[WORD_BITS-1];
        txShift  <= {freshWord[WORD_BITS-2:0], 1'b0};
      end else begin
        txShift  <= freshWord;
      end
    end else if (strobes.txLaunch) begin
      txSerial <= txShift[WORD_BITS-1];
      txShift  <= {txShift[WORD_BITS-2:0], 1'b0};
    end else if (strobes.txDone) begin
      txSerial <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobes.rxFrameStart) begin
        rxShift <= '0;
      end else if (strobes.rxSample) begin
        rxShift <= {rxShift[WORD_BITS-2:0], rxBit};
        if (strobes.rxDone) begin
          rxWord  <= {rxShift[WORD_BITS-2:0], rxBit};
          rxValid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PD_HOLD     = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitClk,
  input  logic                 txFrameSync,
  input  logic                 rxFrameSync,
  input  logic                 rxSerial,
  input  logic                 pwrDownPin,
  input  logic                 lawSelA,
  input  logic                 txLoad,
  input  logic [WORD_BITS-1:0] txWord,
  output logic                 txSerial,
  output logic                 txSerialOe,
  output logic                 slotPullLow,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid
);

  localparam int N_IN = 5;

  logic [N_IN-1:0] syncd;
  logic bcLvl, txSyncLvl, rxSyncLvl, rxBit, pdLvl;
  logic txInSlot, pdActive;
  strobes_t strobes;

  pcm_tdm_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({pwrDownPin, rxSerial, rxFrameSync, txFrameSync, bitClk}),
    .syncOut(syncd)
  );

  assign bcLvl     = syncd[0];
  assign txSyncLvl = syncd[1];
  assign rxSyncLvl = syncd[2];
  assign rxBit     = syncd[3];
  assign pdLvl     = syncd[4];

  pcm_tdm_ctrl #(.PD_HOLD(PD_HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .bcLvl(bcLvl),
    .txSyncLvl(txSyncLvl), .rxSyncLvl(rxSyncLvl), .pdLvl(pdLvl),
    .strobes(strobes), .txInSlot(txInSlot), .pdActive(pdActive)
  );

  pcm_tdm_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lawSelA(lawSelA),
    .txLoad(txLoad), .txWord(txWord), .rxBit(rxBit),
    .txSerial(txSerial), .rxWord(rxWord), .rxValid(rxValid)
  );

  assign txSerialOe  = txInSlot;
  assign slotPullLow = txInSlot;

endmodule

// File: rtl/pcm_tdm_port_chk.sv
`timescale 1ns/1ps
module pcm_tdm_port_chk (
  input logic clk,
  input logic rstN,
  input logic bcLvl,
  input logic pdActive,
  input logic txLaunch,
  input logic txSerial,
  input logic txSerialOe,
  input logic slotPullLow,
  input logic rxValid
);

  AST_OE_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txSerialOe) |-> bcLvl); // R2

  AST_OE_CLOSES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txSerialOe) && !pdActive) |-> !bcLvl); // R6

  AST_DX_HELD_IN_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (txSerialOe && $past(txSerialOe) && !$past(txLaunch)) |-> $stable(txSerial)); // R10

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    pdActive |=> (!txSerialOe && !slotPullLow)); // R9

  AST_PD_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (pdActive && $past(pdActive)) |-> !rxValid); // R9

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R5

endmodule

bind pcm_tdm_port pcm_tdm_port_chk u_chk (
  .clk(clk), .rstN(rstN), .bcLvl(bcLvl), .pdActive(pdActive),
  .txLaunch(strobes.txLaunch), .txSerial(txSerial),
  .txSerialOe(txSerialOe), .slotPullLow(slotPullLow), .rxValid(rxValid)
);

// File: tb/test_pcm_tdm_port.sv
`timescale 1ns/1ps
module test_pcm_tdm_port;

  localparam int NPER = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, bitClk = 1'b0, txFs = 1'b0, rxFs = 1'b0, rxSer = 1'b0;
  logic pdn = 1'b0, lawA = 1'b0, txLoad = 1'b0;
  logic [7:0] txWord = '0;
  logic txSerial, txOe, tsLow, rxValid;
  logic [7:0] rxWord;

  pcm_tdm_port i_pcm_tdm_port (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .txFrameSync(txFs),
    .rxFrameSync(rxFs), .rxSerial(rxSer), .pwrDownPin(pdn),
    .lawSelA(lawA), .txLoad(txLoad), .txWord(txWord),
    .txSerial(txSerial), .txSerialOe(txOe), .slotPullLow(tsLow),
    .rxWord(rxWord), .rxValid(rxValid)
  );

  int vecs = 0, errs = 0, rxCnt = 0;
  logic [7:0] rxGot = '0;
  bit modeLong = 1'b0, pend = 1'b0;
  logic [7:0] pendWord = '0;

  always @(posedge clk) if (rstN && rxValid) begin rxGot = rxWord; rxCnt++; end

  task automatic finishUp;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSync(input logic v);
    txFs = v; rxFs = v;
  endtask

  task automatic loadTx(input logic [7:0] w);
    txWord = w; txLoad = 1'b1;
    stepN(1);
    txLoad = 1'b0; pend = 1'b1; pendWord = w;
  endtask

  // shapeLong: sync width >= 3 periods; riseLow: long sync rises in low phase
  task automatic runFrame(input bit shapeLong, input bit riseLow, input bit twoWide,
                          input logic [7:0] rxW, input bit quiet, input bit midLoad,
                          input logic [7:0] midW, input string tag);
    int fb, c0, k;
    bit inWin, lowWin;
    logic [7:0] expTx;
    fb = modeLong ? (riseLow ? 1 : 0) : ((shapeLong && riseLow) ? 2 : 1);
    expTx = pend ? pendWord : (lawA ? 8'hD5 : 8'hFF);
    if (!quiet) pend = 1'b0;
    c0 = rxCnt;
    for (int p = 0; p < NPER; p++) begin
      bitClk = 1'b1;
      if (p == 0 && !(shapeLong && riseLow)) setSync(1'b1);
      if (!shapeLong && p == 1 && !twoWide) setSync(1'b0);
      if (!shapeLong && p == 2) setSync(1'b0);
      if (shapeLong && p == 4) setSync(1'b0);
      inWin  = (p >= fb) && (p < fb + 8);
      lowWin = (p >= fb) && (p < fb + 7);
      k = 7 - (p - fb);
      rxSer = inWin ? rxW[k] : ((p % 2) == 1);
      stepN(6);
      if (quiet) chk(!txOe && !tsLow, "R9 quiet high", {txOe, tsLow}, 0);
      else begin
        chk(txOe == inWin && tsLow == inWin, "R6 slot high", {txOe, tsLow}, {inWin, inWin});
        if (inWin) chk(txSerial == expTx[k], tag, txSerial, expTx[k]);
      end
      if (midLoad && p == 10) begin loadTx(midW); stepN(1); end
      else stepN(2);
      bitClk = 1'b0;
      stepN(4);
      if (shapeLong && riseLow && p == 0) setSync(1'b1);
      stepN(2);
      if (quiet) chk(!txOe && !tsLow, "R9 quiet low", {txOe, tsLow}, 0);
      else begin
        chk(txOe == lowWin && tsLow == lowWin, "R6 slot low", {txOe, tsLow}, {lowWin, lowWin});
        if (lowWin) chk(txSerial == expTx[k], "R10 hold", txSerial, expTx[k]);
      end
      stepN(2);
    end
    if (quiet) chk(rxCnt == c0, "R9 no rx", rxCnt - c0, 0);
    else begin
      chk(rxCnt == c0 + 1, "R5 rx count", rxCnt - c0, 1);
      chk(rxGot == rxW, "R5 rx word", rxGot, rxW);
      modeLong = shapeLong;
    end
  endtask

  initial begin
    stepN(10);
    chk(txOe == 1'b0 && tsLow == 1'b0 && rxValid == 1'b0, "R1 reset", {txOe, tsLow, rxValid}, 0);
    rstN = 1'b1;
    stepN(5);
    chk(txOe == 1'b0 && tsLow == 1'b0 && rxValid == 1'b0, "R1 after reset", {txOe, tsLow, rxValid}, 0);

    // idle code, mu-law, first frame uses reset short mode
    runFrame(1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h00, "R8 idle mu");

    // short sync sweep, one and two periods wide
    for (int i = 0; i < 24; i++) begin
      loadTx(8'(i * 37 + 5));
      runFrame(1'b0, 1'b0, i[0], 8'(i * 91 + 13), 1'b0, 1'b0, 8'h00, "R2 short tx");
    end

    lawA = 1'b1;
    runFrame(1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'h00, "R8 idle A");
    lawA = 1'b0;

    // first long frame still runs with the latched short rule
    loadTx(8'h96);
    runFrame(1'b1, 1'b0, 1'b0, 8'h69, 1'b0, 1'b0, 8'h00, "R4 switch to long");
    for (int i = 0; i < 16; i++) begin
      loadTx(8'(i * 53 + 1));
      runFrame(1'b1, i[0], 1'b0, 8'(i * 23 + 200), 1'b0, 1'b0, 8'h00, "R3 long tx");
    end

    // long sync rising in the low phase under latched short mode
    runFrame(1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 8'h00, "R4 switch to short");
    loadTx(8'hC3);
    runFrame(1'b1, 1'b1, 1'b0, 8'h7E, 1'b0, 1'b0, 8'h00, "R4 late long under short");
    loadTx(8'h5A);
    runFrame(1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0, 8'h00, "R4 short under long");

    // word staged mid-frame waits a frame and is sent once
    loadTx(8'hE1);
    runFrame(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h2B, "R7 staged before");
    runFrame(1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, "R7 staged mid frame");
    lawA = 1'b1;
    runFrame(1'b0, 1'b0, 1'b0, 8'h42, 1'b0, 1'b0, 8'h00, "R7 sent once");
    lawA = 1'b0;

    // short power-down pulse is ignored
    pdn = 1'b1; stepN(20); pdn = 1'b0; stepN(4);
    loadTx(8'h37);
    runFrame(1'b0, 1'b0, 1'b0, 8'h9C, 1'b0, 1'b0, 8'h00, "R9 glitch ignored");

    // held power-down silences the port and keeps the staged word
    pdn = 1'b1; stepN(100);
    loadTx(8'hB4);
    runFrame(1'b0, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 8'h00, "R9 down");
    runFrame(1'b1, 1'b0, 1'b0, 8'hAA, 1'b1, 1'b0, 8'h00, "R9 down");
    pdn = 1'b0; stepN(4);
    runFrame(1'b0, 1'b0, 1'b0, 8'h5B, 1'b0, 1'b0, 8'h00, "R9 resume kept word");
    runFrame(1'b0, 1'b0, 1'b1, 8'hC7, 1'b0, 1'b0, 8'h00, "R8 idle after resume");

    finishUp();
  end

endmodule